// File: doc/BRIEF.md
# Escaped Reply Packet Transmitter

This block serializes a slave's reply to a master over a byte-wide transmit stream with valid/ready handshaking. When a reply is requested it captures the header fields: destination, source, received command, status, transaction stamp and start address. It then emits the frame. The frame opens with a DLE/STX pair and carries eight header bytes, then a read block streamed in from a payload port. It closes with a DLE/ETX pair and one or two check bytes. Every 0x10 byte in the header, payload or check field is sent twice. The start and end codes are not doubled. The check values are always computed over the bytes before doubling.

Two check styles are available, chosen per frame. The first is a one-byte negated modulo-256 sum. The second is a two-byte reflected CRC using polynomial 0xA001. The block can also send a stand-alone two-byte acknowledge. The acknowledge can be requested at any time, but it is only inserted between frames. Payload contents, the UART, retry policy and acknowledge timing belong to the surrounding logic.

Top module: `reply_pkt_tx`

## Requirements
- R1: A reply frame is sent in this order: 0x10, 0x02, destination, source, reply command, status, stamp low, stamp high, address low, address high, then the payload, then 0x10, 0x03, then the check bytes.
- R2: The reply command byte is the captured command with bit 6 (0x40) set, so 0x01 is sent as 0x41 and 0x08 as 0x48.
- R3: The 16-bit transaction stamp and the 16-bit start address are each sent low byte first, with values exactly as given.
- R4: Any 0x10 value in the header, payload or check field is sent as two consecutive 0x10 bytes. The 0x10 bytes that open the start and end codes are sent once.
- R5: With crc_mode_i low when the frame begins, one check byte follows the end code. It equals the two's complement of the modulo-256 sum of the undoubled header and payload bytes.
- R6: With crc_mode_i high, two check bytes follow, low byte first. They hold a 16-bit CRC that starts at zero, is updated per byte with the reflected 0xA001 shift-and-xor, and covers the undoubled header bytes, the payload bytes and the 0x03 end code.
- R7: When command bit 3 is set (a write, 0x08), the frame has no payload and pay_ready_o stays low. Otherwise payload bytes are accepted through pay_valid_i/pay_ready_o up to and including the one flagged with pay_last_i.
- R8: A one-cycle pulse on ack_i produces the two-byte frame 0x10, 0x06 with no check bytes. If a reply frame is in progress, the acknowledge follows that frame's last byte. If the acknowledge and start_i are both pending while idle, the acknowledge goes first.
- R9: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o stays unchanged.
- R10: done_o is high for exactly the one cycle in which the final check byte of a reply is accepted, and never for an acknowledge frame. start_i is held high until done_o. Header fields and mode are captured when the frame begins.
- R11: The status byte is passed through unchanged, so both nibbles are preserved (0xF1 is sent as 0xF1).
- R12: During reset and right after it, tx_valid_o, pay_ready_o, busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reply request, held high until done_o |
| ack_i | input | 1 | One-cycle request for an acknowledge frame |
| crc_mode_i | input | 1 | 1 selects the two-byte CRC, 0 the one-byte sum |
| dst_i | input | 8 | Destination address |
| src_i | input | 8 | Source address |
| cmd_i | input | 8 | Command as received |
| sts_i | input | 8 | Status byte |
| tns_i | input | 16 | Transaction stamp to echo |
| addr_i | input | 16 | Start address of the block |
| pay_data_i | input | 8 | Payload byte |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_last_i | input | 1 | Marks the final payload byte |
| pay_ready_o | output | 1 | Payload byte accepted this cycle |
| tx_data_o | output | 8 | Byte to the UART |
| tx_valid_o | output | 1 | tx_data_o is valid |
| tx_ready_i | input | 1 | UART accepts the byte |
| busy_o | output | 1 | A frame is being built or drained |
| done_o | output | 1 | Pulse on acceptance of a reply's last byte |

## Verification
A request raised before a rising edge is taken at that edge. The first frame byte appears on tx_valid_o after one more edge, because it passes through the sequencer state and the output register. Each later byte follows one cycle after its predecessor is accepted. done_o is combinational on the final accepted byte, so it is due in the same cycle as that byte.

The bench drives all inputs and samples all outputs on the falling edge. It records a byte only when valid and ready are both high at that point, and moves tx_ready_i shortly after the rising edge. It compares each recorded frame byte by byte with a frame built independently from the requirements. It also checks the index of the byte that carried done_o, and checks for stall-hold violations, with tx_ready_i both always high and gated to one cycle in three.

// File: rtl/reply_tx_pkg.sv
package reply_tx_pkg;
  localparam logic [7:0] CODE_ESC   = 8'h10;
  localparam logic [7:0] CODE_START = 8'h02;
  localparam logic [7:0] CODE_END   = 8'h03;
  localparam logic [7:0] CODE_ACK   = 8'h06;
  localparam logic [7:0] REPLY_FLAG = 8'h40;
  localparam int unsigned HDR_BYTES = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACK_ESC, ST_ACK_CODE, ST_SOF_ESC, ST_SOF_CODE,
    ST_HDR, ST_PAY, ST_EOF_ESC, ST_EOF_CODE, ST_CHK, ST_WAIT
  } tx_state_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rtx_hdr_mux.sv
module rtx_hdr_mux
  import reply_tx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IDX_W = $clog2(HDR_BYTES)
) (
  input  logic [BYTE_W-1:0]   dst_i,
  input  logic [BYTE_W-1:0]   src_i,
  input  logic [BYTE_W-1:0]   cmd_i,
  input  logic [BYTE_W-1:0]   sts_i,
  input  logic [2*BYTE_W-1:0] tns_i,
  input  logic [2*BYTE_W-1:0] addr_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [BYTE_W-1:0]   byte_o
);
  localparam int unsigned HALF = HDR_BYTES / 2;
  logic [BYTE_W-1:0] fields [HDR_BYTES];

  assign fields[0] = dst_i;
  assign fields[1] = src_i;
  assign fields[2] = cmd_i | REPLY_FLAG;
  assign fields[3] = sts_i;

  // 16-bit fields go out low byte first
  for (genvar g = 0; g < 2; g++) begin : g_wide
    assign fields[HALF+g]   = tns_i[g*BYTE_W +: BYTE_W];
    assign fields[HALF+2+g] = addr_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = fields[idx_i];
endmodule

// File: rtl/rtx_check.sv
module rtx_check
  import reply_tx_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sum_en_i,
  input  logic              crc_en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] sum_o,
  output logic [15:0]       crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      crc_o <= '0;
    end else if (clr_i) begin
      sum_o <= '0;
      crc_o <= '0;
    end else begin
      if (sum_en_i) sum_o <= sum_o + data_i;
      if (crc_en_i) crc_o <= crc_step(crc_o, data_i, CRC_POLY);
    end
  end
endmodule

// File: rtl/rtx_escaper.sv
module rtx_escaper
  import reply_tx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_raw_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              end_fire_o,
  output logic              dup_first_o,
  output logic              full_o
);
  logic              full_q, raw_q, last_q, dup_q;
  logic [BYTE_W-1:0] data_q;
  logic              need_dup, final_copy, out_fire, in_fire;

  assign need_dup    = full_q && !raw_q && (data_q == CODE_ESC);
  assign final_copy  = !need_dup || dup_q;
  assign out_fire    = full_q && out_ready_i;
  assign in_ready_o  = !full_q || (out_ready_i && final_copy);
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_valid_o = full_q;
  assign out_data_o  = data_q;
  assign end_fire_o  = out_fire && final_copy && last_q;
  assign dup_first_o = need_dup && !dup_q;
  assign full_o      = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      raw_q  <= 1'b0;
      last_q <= 1'b0;
      dup_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (out_fire && !final_copy) begin
        dup_q <= 1'b1;
      end else if (in_fire) begin
        full_q <= 1'b1;
        dup_q  <= 1'b0;
        data_q <= in_data_i;
        raw_q  <= in_raw_i;
        last_q <= in_last_i;
      end else if (out_fire) begin
        full_q <= 1'b0;
        dup_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/reply_pkt_tx.sv
module reply_pkt_tx
  import reply_tx_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              crc_mode_i,
  input  logic [BYTE_W-1:0] dst_i,
  input  logic [BYTE_W-1:0] src_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] sts_i,
  input  logic [2*BYTE_W-1:0] tns_i,
  input  logic [2*BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] pay_data_i,
  input  logic              pay_valid_i,
  input  logic              pay_last_i,
  output logic              pay_ready_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned IDX_W = $clog2(HDR_BYTES);
  localparam int unsigned WR_BIT = 3;

  tx_state_e           state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [BYTE_W-1:0]   dst_q, src_q, cmd_q, sts_q;
  logic [2*BYTE_W-1:0] tns_q, addr_q;
  logic                crc_q, ack_pend_q;

  logic              seq_valid, seq_raw, seq_last, seq_fire, esc_ready;
  logic [BYTE_W-1:0] seq_data, hdr_byte, sum_val;
  logic [15:0]       crc_val;
  logic              take_ack, take_reply, is_idle, esc_full, esc_dup_first;
  logic              sum_en, crc_en;

  assign is_idle    = (state_q == ST_IDLE);
  assign take_ack   = is_idle && (ack_pend_q || ack_i);
  assign take_reply = is_idle && !take_ack && start_i;

  rtx_hdr_mux #(.BYTE_W(BYTE_W)) u_hdr (
    .dst_i(dst_q), .src_i(src_q), .cmd_i(cmd_q), .sts_i(sts_q),
    .tns_i(tns_q), .addr_i(addr_q), .idx_i(idx_q), .byte_o(hdr_byte)
  );

  assign sum_en = seq_fire && (state_q inside {ST_HDR, ST_PAY});
  assign crc_en = seq_fire && (state_q inside {ST_HDR, ST_PAY, ST_EOF_CODE});

  rtx_check #(.BYTE_W(BYTE_W), .CRC_POLY(CRC_POLY)) u_chk_acc (
    .clk_i, .rst_ni, .clr_i(take_reply), .sum_en_i(sum_en), .crc_en_i(crc_en),
    .data_i(seq_data), .sum_o(sum_val), .crc_o(crc_val)
  );

  always_comb begin
    seq_valid = 1'b0;
    seq_data  = '0;
    seq_raw   = 1'b0;
    seq_last  = 1'b0;
    unique case (state_q)
      ST_ACK_ESC, ST_SOF_ESC, ST_EOF_ESC: begin
        seq_valid = 1'b1; seq_data = CODE_ESC; seq_raw = 1'b1;
      end
      ST_ACK_CODE: begin seq_valid = 1'b1; seq_data = CODE_ACK;   seq_raw = 1'b1; end
      ST_SOF_CODE: begin seq_valid = 1'b1; seq_data = CODE_START; seq_raw = 1'b1; end
      ST_EOF_CODE: begin seq_valid = 1'b1; seq_data = CODE_END;   seq_raw = 1'b1; end
      ST_HDR:      begin seq_valid = 1'b1; seq_data = hdr_byte; end
      ST_PAY:      begin seq_valid = pay_valid_i; seq_data = pay_data_i; end
      ST_CHK: begin
        seq_valid = 1'b1;
        if (crc_q) begin
          seq_data = idx_q[0] ? crc_val[15:8] : crc_val[7:0];
          seq_last = idx_q[0];
        end else begin
          seq_data = (~sum_val) + 1'b1;
          seq_last = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign seq_fire    = seq_valid && esc_ready;
  assign pay_ready_o = (state_q == ST_PAY) && esc_ready;

  rtx_escaper #(.BYTE_W(BYTE_W)) u_esc (
    .clk_i, .rst_ni,
    .in_valid_i(seq_valid), .in_data_i(seq_data), .in_raw_i(seq_raw),
    .in_last_i(seq_last), .in_ready_o(esc_ready),
    .out_valid_o(tx_valid_o), .out_data_o(tx_data_o), .out_ready_i(tx_ready_i),
    .end_fire_o(done_o), .dup_first_o(esc_dup_first), .full_o(esc_full)
  );

  assign busy_o = !is_idle || esc_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      ack_pend_q <= 1'b0;
      crc_q      <= 1'b0;
      dst_q      <= '0;
      src_q      <= '0;
      cmd_q      <= '0;
      sts_q      <= '0;
      tns_q      <= '0;
      addr_q     <= '0;
    end else begin
      ack_pend_q <= (ack_pend_q || ack_i) && !take_ack;
      unique case (state_q)
        ST_IDLE: begin
          if (take_ack) begin
            state_q <= ST_ACK_ESC;
          end else if (take_reply) begin
            state_q <= ST_SOF_ESC;
            dst_q   <= dst_i;
            src_q   <= src_i;
            cmd_q   <= cmd_i;
            sts_q   <= sts_i;
            tns_q   <= tns_i;
            addr_q  <= addr_i;
            crc_q   <= crc_mode_i;
          end
        end
        ST_ACK_ESC:  if (seq_fire) state_q <= ST_ACK_CODE;
        ST_ACK_CODE: if (seq_fire) state_q <= ST_IDLE;
        ST_SOF_ESC:  if (seq_fire) state_q <= ST_SOF_CODE;
        ST_SOF_CODE: if (seq_fire) begin state_q <= ST_HDR; idx_q <= '0; end
        ST_HDR: if (seq_fire) begin
          if (idx_q == IDX_W'(HDR_BYTES - 1)) begin
            state_q <= cmd_q[WR_BIT] ? ST_EOF_ESC : ST_PAY;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PAY:      if (seq_fire && pay_last_i) state_q <= ST_EOF_ESC;
        ST_EOF_ESC:  if (seq_fire) state_q <= ST_EOF_CODE;
        ST_EOF_CODE: if (seq_fire) begin state_q <= ST_CHK; idx_q <= '0; end
        ST_CHK: if (seq_fire) begin
          if (seq_last) state_q <= ST_WAIT;
          else idx_q <= idx_q + 1'b1;
        end
        ST_WAIT: if (done_o) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reply_pkt_tx_chk.sv
module reply_pkt_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       done_o,
  input logic       pay_ready_o,
  input logic       busy_o,
  input logic       esc_dup_first
);
  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R10
  done_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_valid_o && tx_ready_i);

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  escape_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && esc_dup_first |=> tx_valid_o && tx_data_o == 8'h10);

  // R7
  pay_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> busy_o);
endmodule

bind reply_pkt_tx reply_pkt_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_data_o(tx_data_o), .done_o(done_o), .pay_ready_o(pay_ready_o),
  .busy_o(busy_o), .esc_dup_first(esc_dup_first)
);

// File: tb/reply_pkt_tx_tb_top.sv
`timescale 1ns/1ps
module reply_pkt_tx_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, ack_i = 0, crc_mode_i = 0;
  logic [7:0] dst_i = 0, src_i = 0, cmd_i = 0, sts_i = 0;
  logic [15:0] tns_i = 0, addr_i = 0;
  logic [7:0] pay_data_i = 0;
  logic pay_valid_i = 0, pay_last_i = 0, pay_ready_o;
  logic [7:0] tx_data_o;
  logic tx_valid_o, tx_ready_i = 1'b1, busy_o, done_o;

  always #2 clk_i = ~clk_i;

  reply_pkt_tx dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] cap [512];
  logic [7:0] expv [512];
  logic [7:0] pay [64];
  int cap_n = 0, exp_n = 0, pay_n = 0, done_cnt = 0, done_idx = 0, reply_end = 0;
  int hold_err = 0, pay_seen = 0, cyc = 0;
  bit stall_mode = 0, prev_stall = 0;
  logic [7:0] prev_data = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expd);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expd);
    end
  endtask

  always @(posedge clk_i) begin
    #1;
    cyc++;
    tx_ready_i = stall_mode ? (cyc % 3 == 0) : 1'b1;
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_stall && !(tx_valid_o && tx_data_o == prev_data)) hold_err++;
      if (tx_valid_o && tx_ready_i) begin
        cap[cap_n] = tx_data_o;
        cap_n++;
        if (done_o) begin done_cnt++; done_idx = cap_n; end
      end
      if (pay_ready_o) pay_seen++;
      prev_stall = tx_valid_o && !tx_ready_i;
      prev_data  = tx_data_o;
    end
  end

  task automatic add_raw(input logic [7:0] b);
    expv[exp_n] = b; exp_n++;
  endtask
  task automatic add_esc(input logic [7:0] b);
    add_raw(b);
    if (b == 8'h10) add_raw(8'h10);
  endtask
  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic add_ack();
    add_raw(8'h10); add_raw(8'h06);
  endtask

  task automatic add_reply();
    logic [7:0] body [80];
    int bn = 0;
    logic [7:0] s = 0;
    logic [15:0] c = 0;
    body[0] = dst_i; body[1] = src_i; body[2] = cmd_i | 8'h40; body[3] = sts_i;
    body[4] = tns_i[7:0]; body[5] = tns_i[15:8]; body[6] = addr_i[7:0]; body[7] = addr_i[15:8];
    bn = 8;
    if (!cmd_i[3]) for (int i = 0; i < pay_n; i++) begin body[bn] = pay[i]; bn++; end
    add_raw(8'h10); add_raw(8'h02);
    for (int i = 0; i < bn; i++) begin
      add_esc(body[i]); s = s + body[i]; c = crc_upd(c, body[i]);
    end
    add_raw(8'h10); add_raw(8'h03);
    c = crc_upd(c, 8'h03);
    if (crc_mode_i) begin add_esc(c[7:0]); add_esc(c[15:8]); end
    else add_esc((~s) + 8'd1);
    reply_end = exp_n;
  endtask

  task automatic clear_cap();
    cap_n = 0; exp_n = 0; done_cnt = 0; done_idx = 0; hold_err = 0; pay_seen = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  // pre_ack: ack raised with start; mid_ack: ack pulsed during the reply
  task automatic run_reply(input bit pre_ack, input bit mid_ack);
    if (pre_ack) begin add_ack(); ack_i = 1'b1; end
    add_reply();
    if (mid_ack) add_ack();
    start_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    if (!cmd_i[3]) for (int i = 0; i < pay_n; i++) begin
      bit taken = 0;
      pay_valid_i = 1'b1; pay_data_i = pay[i]; pay_last_i = (i == pay_n - 1);
      while (!taken) begin
        taken = pay_ready_o;
        @(negedge clk_i);
      end
    end
    pay_valid_i = 1'b0; pay_last_i = 1'b0;
    if (mid_ack) begin ack_i = 1'b1; @(negedge clk_i); ack_i = 1'b0; end
    while (!done_o) @(negedge clk_i);
    start_i = 1'b0;
    wait_idle();
  endtask

  task automatic cmp_frame(input string req);
    int bad = -1;
    chk(cap_n == exp_n, {req, " length"}, cap_n, exp_n);
    for (int i = 0; i < exp_n; i++) if (bad < 0 && cap[i] !== expv[i]) bad = i;
    if (bad >= 0) chk(0, {req, " byte"}, cap[bad], expv[bad]);
    else chk(1, req, 0, 0);
    chk(hold_err == 0, "R9 stall hold", hold_err, 0);
  endtask

  task automatic set_hdr(input logic [7:0] d, s, c, st, input logic [15:0] t, a, input bit m);
    dst_i = d; src_i = s; cmd_i = c; sts_i = st; tns_i = t; addr_i = a; crc_mode_i = m;
  endtask

  task automatic t_reset();
    chk(!tx_valid_o && !busy_o && !done_o && !pay_ready_o, "R12 reset outputs",
        {tx_valid_o, busy_o, done_o, pay_ready_o}, 0);
  endtask

  task automatic t_read_sum();
    clear_cap();
    set_hdr(8'h08, 8'h00, 8'h01, 8'h00, 16'hA57E, 16'h0280, 0);
    pay_n = 4; pay[0] = 8'h34; pay[1] = 8'h12; pay[2] = 8'hCD; pay[3] = 8'hAB;
    run_reply(0, 0);
    cmp_frame("R1 R5 R7 read sum frame");
    chk(cap[4] == 8'h41, "R2 read reply code", cap[4], 8'h41);
    chk(cap[6] == 8'h7E && cap[7] == 8'hA5, "R3 stamp order", {cap[6], cap[7]}, 16'h7EA5);
    chk(done_cnt == 1 && done_idx == reply_end, "R10 done at last byte", done_idx, reply_end);
  endtask

  task automatic t_write_sum();
    clear_cap();
    set_hdr(8'h09, 8'h00, 8'h08, 8'h00, 16'h0003, 16'h01C0, 0);
    pay_n = 0;
    run_reply(0, 0);
    cmp_frame("R7 write frame");
    chk(cap[4] == 8'h48, "R2 write reply code", cap[4], 8'h48);
    chk(pay_seen == 0, "R7 no payload accepted", pay_seen, 0);
  endtask

  task automatic t_escape();
    logic [7:0] s;
    clear_cap();
    set_hdr(8'h10, 8'h00, 8'h01, 8'h02, 16'h1010, 16'h0280, 0);
    pay_n = 3; pay[0] = 8'h10; pay[1] = 8'h55;
    s = 8'h10 + 8'h41 + 8'h02 + 8'h10 + 8'h10 + 8'h80 + 8'h02 + 8'h10 + 8'h55;
    pay[2] = 8'hF0 - s;   // forces the sum check byte to 0x10
    run_reply(0, 0);
    cmp_frame("R4 escaped frame");
    chk(cap[cap_n-1] == 8'h10 && cap[cap_n-2] == 8'h10, "R4 check byte doubled",
        {cap[cap_n-2], cap[cap_n-1]}, 16'h1010);
    chk(cap[0] == 8'h10 && cap[1] == 8'h02, "R4 start code single", cap[1], 8'h02);
  endtask

  task automatic t_crc_stall();
    clear_cap();
    stall_mode = 1;
    set_hdr(8'h0A, 8'h00, 8'h01, 8'hF1, 16'h1234, 16'h05A0, 1);
    pay_n = 5;
    for (int i = 0; i < 5; i++) pay[i] = 8'(8'h0E + 3 * i);
    run_reply(0, 0);
    stall_mode = 0;
    cmp_frame("R6 R9 crc frame under stall");
    chk(cap[5] == 8'hF1, "R11 status nibbles kept", cap[5], 8'hF1);
    chk(done_cnt == 1 && done_idx == reply_end, "R10 done crc", done_idx, reply_end);
  endtask

  task automatic t_crc_write();
    clear_cap();
    set_hdr(8'h08, 8'h00, 8'h08, 8'hE0, 16'hFFFF, 16'h0400, 1);
    pay_n = 0;
    run_reply(0, 0);
    cmp_frame("R6 R7 crc write frame");
  endtask

  task automatic t_ack_alone();
    clear_cap();
    add_ack();
    ack_i = 1'b1; @(negedge clk_i); ack_i = 1'b0;
    wait_idle();
    cmp_frame("R8 ack frame");
    chk(done_cnt == 0, "R8 no done for ack", done_cnt, 0);
  endtask

  task automatic t_ack_mid();
    clear_cap();
    set_hdr(8'h08, 8'h00, 8'h01, 8'h00, 16'h0042, 16'h0280, 0);
    pay_n = 2; pay[0] = 8'h01; pay[1] = 8'h02;
    run_reply(0, 1);
    cmp_frame("R8 ack after reply");
    chk(done_cnt == 1 && done_idx == reply_end, "R8 R10 done before ack", done_idx, reply_end);
  endtask

  task automatic t_ack_prio();
    clear_cap();
    set_hdr(8'h0B, 8'h00, 8'h01, 8'h01, 16'h0101, 16'h0600, 1);
    pay_n = 1; pay[0] = 8'h77;
    run_reply(1, 0);
    cmp_frame("R8 ack priority");
    chk(cap[1] == 8'h06, "R8 ack first", cap[1], 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_read_sum();
    t_write_sum();
    t_escape();
    t_crc_stall();
    t_crc_write();
    t_ack_alone();
    t_ack_mid();
    t_ack_prio();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule